// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is a target on a two-wire serial bus (clock line plus open-drain data line) with a 128-byte memory behind it. It runs on a fast system clock and oversamples both bus lines through synchronizers. It never drives the data line high. It only asserts an output-enable that pulls the line low, and the pad and pull-up resolve the bus.

A transfer opens with a START, after which the master sends one byte that carries the 7-bit word address and the transfer direction. In a write, the following bytes go into a page buffer of four entries, indexed by the low address bits. The buffer is written into the array when the STOP arrives, and an internal write cycle of `WR_CYCLES` system clocks follows. During that cycle the target is deaf and mute, so a master can poll for the end of the cycle by checking for an acknowledge. In a read, the target shifts bytes out MSB first and advances through the whole array for as long as the master acknowledges.

Top module: `tw_eeprom`

## Requirements
- R1: After reset, sdaOe is low and every memory byte reads back as 0x00.
- R2: START is a falling SDA while SCL is high, and STOP is a rising SDA while SCL is high. In the first byte after START, bits 7..1 hold the word address and bit 0 is the direction (0 = write, 1 = read). An idle target pulls SDA low for the whole ninth clock of that byte.
- R3: In a write, each data byte is acknowledged in its ninth clock and is stored starting at the word address. A read that follows the STOP returns the stored bytes.
- R4: During a write, only address bits 1..0 advance after each data byte. A fifth or later byte wraps to the start of the same four-byte page and overwrites the byte stored there earlier.
- R5: A STOP that ends a write holding at least one data byte starts a busy period of WR_CYCLES clocks. During that period the target acknowledges nothing and ignores all bus traffic, including START, STOP and data, so memory is unchanged by it.
- R6: A STOP after a write address with no data byte starts no busy period.
- R7: Read data goes out MSB first. SDA changes only after a falling SCL and holds steady through each SCL-high phase.
- R8: When the master acknowledges a read byte (SDA low in the ninth clock), the full 7-bit address increments, wrapping from 127 to 0, and the next byte follows.
- R9: After a master no-acknowledge, the target releases SDA and drives nothing until the next START.
- R10: A START in the middle of a byte aborts the transfer and restarts address reception. Data bytes not yet followed by STOP are discarded and start no busy period.
- R11: While the master is sending bits, sdaOe stays low except in the target's acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line, asynchronous |
| sdaIn | input | 1 | Resolved bus data line, asynchronous |
| sdaOe | output | 1 | When high, the pad pulls SDA low |

## Verification
The bench sends six bytes into one page. A design that let the address carry past bit 1 would spill the extra bytes into the next page and leave the early bytes of the target page intact. A read that starts at address 126 checks the wrap to 0; if the carry were masked the way it is in a write, the read would return to 124 instead. A write aborted by a repeated START in mid-byte must leave memory untouched and must not make the target busy, which catches a design that commits on every acknowledged byte. A complete write sent during the busy period must be neither acknowledged nor stored.

// File: rtl/tw_pkg.sv
package tw_pkg;

  // Strobes from the control FSM to the datapath, one cycle wide each.
  typedef struct packed {
    logic shiftIn;    // shift the sampled SDA bit into the receive register
    logic takeAddr;   // latch word address from the received first byte
    logic storeByte;  // place received byte in page buffer, step low address bits
    logic loadTx;     // fetch the addressed byte into the transmit register
    logic shiftTx;    // move the next transmit bit to the MSB
    logic incAddr;    // step the full word address (sequential read)
    logic commit;     // copy valid page buffer entries into the array
    logic clearBuf;   // drop all pending page buffer entries
  } twStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } twState_t;

endpackage

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
#(
  parameter int WR_CYCLES = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      txMsb,
  input  logic      bufAny,
  output twStrobe_t strb,
  output logic      sdaOe,
  output logic      busy,
  output logic      sclSync
);

  localparam int BUSY_W = $clog2(WR_CYCLES + 1);

  logic [1:0] sclPipe, sdaPipe;
  logic       sclD, sdaD, sclS, sdaS;
  logic       sclRise, sclFall, startC, stopC;

  twState_t    state;
  logic [3:0]  bitCnt;
  logic        isAddr, rwBit, mAck;
  logic [BUSY_W-1:0] busyCnt;

  // Synchronizers plus one delay stage for edge detection; run even when busy.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= 2'b11;
      sdaPipe <= 2'b11;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[0], sclIn};
      sdaPipe <= {sdaPipe[0], sdaIn};
      sclD    <= sclPipe[1];
      sdaD    <= sdaPipe[1];
    end
  end

  assign sclS    = sclPipe[1];
  assign sdaS    = sdaPipe[1];
  assign sclSync = sclS;
  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startC  = sclS & sclD & sdaD & ~sdaS;
  assign stopC   = sclS & sclD & ~sdaD & sdaS;
  assign busy    = (busyCnt != '0);

  always_comb begin
    strb = '0;
    if (!busy) begin
      if (startC) begin
        strb.clearBuf = 1'b1;
      end else if (stopC) begin
        strb.commit = bufAny;
      end else begin
        unique case (state)
          ST_RX: begin
            strb.shiftIn   = sclRise;
            strb.takeAddr  = sclFall && (bitCnt == 4'd8) && isAddr;
            strb.storeByte = sclFall && (bitCnt == 4'd8) && !isAddr;
          end
          ST_ACK:  strb.loadTx  = sclFall && isAddr && rwBit;
          ST_TX:   strb.shiftTx = sclFall && (bitCnt != 4'd7);
          ST_MACK: begin
            strb.incAddr = sclRise && !sdaS;
            strb.loadTx  = sclFall && mAck;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      isAddr  <= 1'b0;
      rwBit   <= 1'b0;
      mAck    <= 1'b0;
      busyCnt <= '0;
    end else if (busy) begin
      busyCnt <= busyCnt - 1'b1;
      state   <= ST_IDLE;
    end else if (startC) begin
      state  <= ST_RX;
      bitCnt <= '0;
      isAddr <= 1'b1;
    end else if (stopC) begin
      state <= ST_IDLE;
      if (bufAny) busyCnt <= BUSY_W'(WR_CYCLES);
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (isAddr && bitCnt == 4'd7) rwBit <= sdaS;
          end else if (sclFall && bitCnt == 4'd8) begin
            state <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            isAddr <= 1'b0;
            state  <= (isAddr && rwBit) ? ST_TX : ST_RX;
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) state <= ST_MACK;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            mAck <= ~sdaS;
          end else if (sclFall) begin
            bitCnt <= '0;
            state  <= mAck ? ST_TX : ST_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = !busy && ((state == ST_ACK) || (state == ST_TX && !txMsb));

endmodule

// File: rtl/tw_dp.sv
module tw_dp
  import tw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaBit,
  input  twStrobe_t         strb,
  output logic              txMsb,
  output logic              bufAny,
  output logic [ADDR_W-1:0] wordAddr
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rxSh, txSh;
  logic [DATA_W-1:0] pageBuf [PAGE_N];
  logic [PAGE_N-1:0] bufVld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSh <= '0;
    else if (strb.shiftIn) rxSh <= {rxSh[DATA_W-2:0], sdaBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddr <= '0;
    end else if (strb.takeAddr) begin
      wordAddr <= rxSh[DATA_W-1:DATA_W-ADDR_W];
    end else if (strb.storeByte) begin
      wordAddr[PAGE_W-1:0] <= wordAddr[PAGE_W-1:0] + 1'b1;
    end else if (strb.incAddr) begin
      wordAddr <= wordAddr + 1'b1;
    end
  end

  // One slot per byte of the page.
  for (genvar g = 0; g < PAGE_N; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pageBuf[g] <= '0;
        bufVld[g]  <= 1'b0;
      end else if (strb.clearBuf || strb.commit) begin
        bufVld[g] <= 1'b0;
      end else if (strb.storeByte && wordAddr[PAGE_W-1:0] == PAGE_W'(g)) begin
        pageBuf[g] <= rxSh;
        bufVld[g]  <= 1'b1;
      end
    end
  end

  assign bufAny = |bufVld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.commit) begin
      for (int i = 0; i < PAGE_N; i++)
        if (bufVld[i]) mem[{wordAddr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txSh <= '0;
    else if (strb.loadTx) txSh <= mem[wordAddr];
    else if (strb.shiftTx) txSh <= {txSh[DATA_W-2:0], 1'b0};
  end

  assign txMsb = txSh[DATA_W-1];

endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom
  import tw_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 2,
  parameter int WR_CYCLES = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  localparam int ADDR_W = DATA_W - 1;

  twStrobe_t         strb;
  logic              txMsb, bufAny, busy, sclSync;
  logic [ADDR_W-1:0] wordAddr;
  logic              sdaBit;

  assign sdaBit = sdaIn;

  tw_ctrl #(.WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .txMsb   (txMsb),
    .bufAny  (bufAny),
    .strb    (strb),
    .sdaOe   (sdaOe),
    .busy    (busy),
    .sclSync (sclSync)
  );

  // Datapath samples a re-synchronized copy: shiftIn fires only on a
  // synchronized SCL rise, long after SDA has settled at the pin.
  logic [1:0] sdaDpSync;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdaDpSync <= 2'b11;
    else sdaDpSync <= {sdaDpSync[0], sdaBit};
  end

  tw_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sdaBit   (sdaDpSync[1]),
    .strb     (strb),
    .txMsb    (txMsb),
    .bufAny   (bufAny),
    .wordAddr (wordAddr)
  );

endmodule

// File: rtl/tw_eeprom_chk.sv
module tw_eeprom_chk
  import tw_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic              busy,
  input logic              sclSync,
  input twStrobe_t         strb,
  input logic [ADDR_W-1:0] wordAddr
);

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe); // R5

  AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> busy); // R5

  AST_PULL_IN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !$past(sclSync)); // R7

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeByte |=> $stable(wordAddr[ADDR_W-1:PAGE_W])); // R4

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.incAddr |=> (wordAddr == ADDR_W'($past(wordAddr) + 1'b1))); // R8

endmodule

bind tw_eeprom tw_eeprom_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sdaOe    (sdaOe),
  .busy     (busy),
  .sclSync  (sclSync),
  .strb     (strb),
  .wordAddr (wordAddr)
);

// File: tb/test_tw_eeprom.sv
module test_tw_eeprom;

  localparam int WRC  = 1000;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic sdaLine;

  assign sdaLine = sdaM & ~sdaOe;

  always #4 clk = ~clk;

  tw_eeprom #(.WR_CYCLES(WRC)) i_tw_eeprom (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (scl),
    .sdaIn (sdaLine),
    .sdaOe (sdaOe)
  );

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  longint busyEnd = 0;
  logic [7:0] refMem [128];
  logic [7:0] wq [$];

  // Per-clock comparison of sdaOe against the model during SCL-high phases.
  bit chkOn = 0;
  bit expOe = 0;
  bit bitBad = 0;
  bit badVal = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (chkOn && sdaOe !== expOe) begin
      bitBad = 1'b1;
      badVal = sdaOe;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit modelBusy();
    return cyc < busyEnd;
  endfunction

  task automatic busBit(input bit m, input bit e, input string req);
    scl = 1'b0;
    tick(HALF / 2);
    sdaM = m;
    tick(HALF / 2);
    expOe = e;
    bitBad = 1'b0;
    badVal = e;
    scl = 1'b1;
    chkOn = 1'b1;
    tick(HALF);
    chkOn = 1'b0;
    chk(!bitBad, req, "sdaOe during SCL high", int'(badVal), int'(e));
  endtask

  task automatic sendStart();
    scl = 1'b0;
    tick(HALF / 2);
    sdaM = 1'b1;
    tick(HALF / 2);
    scl = 1'b1;
    tick(HALF / 2);
    sdaM = 1'b0;
    tick(HALF / 2);
  endtask

  task automatic sendStop();
    scl = 1'b0;
    tick(HALF / 2);
    sdaM = 1'b0;
    tick(HALF / 2);
    scl = 1'b1;
    tick(HALF / 2);
    sdaM = 1'b1;
    tick(HALF / 2);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit ack, input string req);
    for (int i = 7; i >= 0; i--) busBit(b[i], 1'b0, "R11");
    busBit(1'b1, ack, req);
  endtask

  task automatic readByte(input logic [7:0] exp, input bit mAck, input string req);
    for (int i = 7; i >= 0; i--) busBit(1'b1, ~exp[i], req);
    busBit(~mAck, 1'b0, req);
  endtask

  // Full write transfer of the bytes in wq; model commits on STOP.
  task automatic writeSeq(input logic [6:0] addr, input string req);
    bit ack;
    sendStart();
    ack = !modelBusy();
    sendByte({addr, 1'b0}, ack, req);
    foreach (wq[k]) sendByte(wq[k], ack, req);
    sendStop();
    if (ack && wq.size() > 0) begin
      foreach (wq[k]) refMem[{addr[6:2], 2'(addr[1:0] + k)}] = wq[k];
      busyEnd = cyc + WRC;
    end
    wq.delete();
  endtask

  task automatic readSeq(input logic [6:0] addr, input int n, input string req);
    bit ack;
    sendStart();
    ack = !modelBusy();
    sendByte({addr, 1'b1}, ack, req);
    for (int k = 0; k < n; k++)
      readByte(refMem[7'(addr + k)], k < n - 1, req);
    sendStop();
  endtask

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) refMem[i] = 8'h00;
    tick(5);
    chk(sdaOe == 1'b0, "R1", "sdaOe in reset", int'(sdaOe), 0);
    rstN = 1'b1;
    tick(10);
    chk(sdaOe == 1'b0, "R1", "sdaOe after reset", int'(sdaOe), 0);

    // R1: memory cleared
    readSeq(7'h00, 2, "R1");

    // R2 / R3: byte write, then R5 polling while busy
    wq.push_back(8'hA5);
    writeSeq(7'h05, "R2");
    sendStart();
    sendByte({7'h05, 1'b0}, 1'b0, "R5");
    sendStop();
    tick(WRC + 50);
    readSeq(7'h05, 1, "R3");

    // R6: address-only write, immediately readable (no busy)
    writeSeq(7'h30, "R6");
    readSeq(7'h30, 1, "R6");

    // R4: six bytes into page 0x10..0x13 starting at 0x12
    wq = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
    writeSeq(7'h12, "R4");
    tick(WRC + 50);
    readSeq(7'h10, 5, "R4");

    // R8: sequential read wraps 127 -> 0
    wq = '{8'h11, 8'h22};
    writeSeq(7'h7E, "R8");
    tick(WRC + 50);
    wq = '{8'h33, 8'h44};
    writeSeq(7'h00, "R8");
    tick(WRC + 50);
    readSeq(7'h7E, 4, "R8");
    readSeq(7'h01, 1, "R7");

    // R9: master nack releases the line for the rest of the byte
    sendStart();
    sendByte({7'h05, 1'b1}, 1'b1, "R9");
    readByte(refMem[7'h05], 1'b0, "R9");
    for (int i = 0; i < 9; i++) busBit(1'b1, 1'b0, "R9");
    sendStop();

    // R10: repeated START mid-byte discards pending data, no busy
    sendStart();
    sendByte({7'h40, 1'b0}, 1'b1, "R10");
    sendByte(8'h99, 1'b1, "R10");
    busBit(1'b1, 1'b0, "R10");
    busBit(1'b0, 1'b0, "R10");
    busBit(1'b1, 1'b0, "R10");
    sendStart();
    sendByte({7'h40, 1'b1}, 1'b1, "R10");
    readByte(refMem[7'h40], 1'b0, "R10");
    sendStop();

    // R5: full write during busy is ignored
    wq.push_back(8'h77);
    writeSeq(7'h50, "R5");
    sendStart();
    sendByte({7'h51, 1'b0}, 1'b0, "R5");
    sendByte(8'h88, 1'b0, "R5");
    sendStop();
    tick(WRC + 50);
    readSeq(7'h50, 2, "R5");

    tick(20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule